// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative translation lookaside buffer with a parameterised number of entries (32 by default). Each entry holds one key and two physical halves. The key is a virtual page-pair number, a page mask and an 8-bit address-space ID. Each half maps one page of the even/odd pair. A lookup presents a 32-bit virtual address, the current address-space ID and an access type. The buffer compares every key in parallel and returns the translated physical address, a hit flag, the valid and writable bits of the selected half, its 3-bit cache attribute, the index of the matching entry and a fault code.

Software fills the table through a write port that loads one entry at a chosen index. A probe port takes a page-pair number and an ID and returns the matching index, or a not-found flag. Software also chooses victims for replacement and walks the page tables. The table is registered and the lookup path is combinational, so a lookup reflects every write completed on an earlier clock edge.

Top module: `pair_tlb`

## Requirements
- R1: For a hit, physical address bits 11:0 equal virtual address bits 11:0.
- R2: An entry matches when its page-pair number equals virtual address bits 31:13 on every bit not ignored by its mask, and its stored ID equals `lk_asid` (or the entry is global). On a match `lk_hit` is 1 and `lk_idx` gives the entry. Otherwise `lk_hit` is 0.
- R3: With a zero mask, virtual bit 12 picks the half. A 0 selects the even half (`wr_lo0`) and a 1 selects the odd half (`wr_lo1`). Each half has its own frame number.
- R4: Mask bit k (k = 0..11) excludes virtual bit 13+k from the compare and passes virtual bit 12+k into physical bit 12+k in place of the frame bit. The half is chosen by the virtual bit just above the passed bits, which is bit 12 plus the number of mask ones. Legal masks are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF (4 KB to 16 MB pages).
- R5: The stored global flag is the AND of bit 0 of `wr_lo0` and bit 0 of `wr_lo1`. A global entry matches under any ID.
- R6: A half word is laid out as bit 0 global, bit 1 valid, bit 2 writable, bits 5:3 cache attribute (3 cacheable, 2 uncached) and bits 25:6 frame number. `lk_valid`, `lk_dirty` and `lk_cattr` report the selected half.
- R7: `lk_acc` is 0 for fetch, 1 for load and 2 for store. `lk_fault` is 1 on a miss, 2 on a hit to an invalid half, 3 on a store to a valid half that is not writable, and 0 otherwise.
- R8: `pr_idx` is {0, index} when an entry matches the probe key under the same mask and global rules, and has its MSB set when none matches.
- R9: When several entries match, the lowest index is reported by both lookup and probe.
- R10: After reset no entry matches. A write is not seen before its clock edge and is seen right after it, and it replaces the previous content of that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space ID |
| lk_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| lk_pa | output | 32 | Translated physical address |
| lk_hit | output | 1 | Some entry matched |
| lk_valid | output | 1 | Valid bit of the selected half |
| lk_dirty | output | 1 | Writable bit of the selected half |
| lk_cattr | output | 3 | Cache attribute of the selected half |
| lk_idx | output | 5 | Index of the matching entry |
| lk_fault | output | 2 | Fault code |
| wr_en | input | 1 | Load an entry on this edge |
| wr_idx | input | 5 | Entry to load |
| wr_vpn2 | input | 19 | Page-pair number |
| wr_mask | input | 12 | Page mask |
| wr_asid | input | 8 | Address-space ID of the entry |
| wr_lo0 | input | 26 | Even half word |
| wr_lo1 | input | 26 | Odd half word |
| pr_vpn2 | input | 19 | Probe page-pair number |
| pr_asid | input | 8 | Probe address-space ID |
| pr_idx | output | 6 | Probe result, MSB set when not found |

## Verification
The assertions assume that every written mask is one of the seven legal patterns, and they check this on each write. They also assume that `lk_acc` never takes the value 3. The bench writes only legal masks and the three defined access types. It creates overlapping entries on purpose in one test only, to exercise the lowest-index rule. None of the assertions depends on matches being unique.

// File: rtl/pair_tlb.sv
module pair_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - 13,
  localparam int LO_W   = PFN_W + 6,
  localparam int HALF_W = LO_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  output logic [PFN_W+11:0] lk_pa,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [2:0]        lk_cattr,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [1:0]        lk_fault,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic [VPN_W-1:0]  pr_vpn2,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [IDX_W:0]    pr_idx
);

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [MASK_W-1:0] e_mask [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [HALF_W-1:0] e_even [ENTRIES];
  logic [HALF_W-1:0] e_odd  [ENTRIES];
  logic [ENTRIES-1:0] e_glob, e_used;

  always_ff @(posedge clk) begin
    if (rst) e_used <= '0;
    else if (wr_en) e_used[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]  <= wr_vpn2;
      e_mask[wr_idx] <= wr_mask;
      e_asid[wr_idx] <= wr_asid;
      e_glob[wr_idx] <= wr_lo0[0] & wr_lo1[0];
      e_even[wr_idx] <= wr_lo0[LO_W-1:1];
      e_odd[wr_idx]  <= wr_lo1[LO_W-1:1];
    end
  end

  logic [ENTRIES-1:0] lk_m, pr_m;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] care;
    assign care    = ~{{(VPN_W-MASK_W){1'b0}}, e_mask[i]};
    assign lk_m[i] = e_used[i] && (((lk_va[VA_W-1:13] ^ e_vpn[i]) & care) == '0)
                     && (e_glob[i] || e_asid[i] == lk_asid);
    assign pr_m[i] = e_used[i] && (((pr_vpn2 ^ e_vpn[i]) & care) == '0)
                     && (e_glob[i] || e_asid[i] == pr_asid);
  end

  logic [IDX_W-1:0] lk_sel, pr_sel;

  always_comb begin
    lk_sel = '0;
    pr_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_sel = IDX_W'(i);
      if (pr_m[i]) pr_sel = IDX_W'(i);
    end
  end

  logic [MASK_W-1:0] sm;
  logic [MASK_W:0]   span, top;
  logic              odd;
  logic [HALF_W-1:0] half;
  logic [PFN_W-1:0]  ext, pfn;

  assign sm   = e_mask[lk_sel];
  assign span = {sm, 1'b1};
  assign top  = span & ~(span >> 1);
  assign odd  = |(lk_va[MASK_W+12:12] & top);
  assign half = odd ? e_odd[lk_sel] : e_even[lk_sel];
  assign ext  = {{(PFN_W-MASK_W){1'b0}}, sm};
  assign pfn  = half[HALF_W-1:5];

  assign lk_hit   = |lk_m;
  assign lk_idx   = lk_sel;
  assign lk_valid = half[0];
  assign lk_dirty = half[1];
  assign lk_cattr = half[4:2];
  assign lk_pa    = {(pfn & ~ext) | (lk_va[PFN_W+11:12] & ext), lk_va[11:0]};

  always_comb begin
    if (!lk_hit)                          lk_fault = 2'd1;
    else if (!lk_valid)                   lk_fault = 2'd2;
    else if (lk_acc == 2'd2 && !lk_dirty) lk_fault = 2'd3;
    else                                  lk_fault = 2'd0;
  end

  assign pr_idx = {~|pr_m, pr_sel};

endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int IDX_W  = 5,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int MASK_W = 12,
  parameter int VPN_W  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic [VA_W-1:0]   lk_va,
  input logic [ASID_W-1:0] lk_asid,
  input logic [PA_W-1:0]   lk_pa,
  input logic              lk_hit,
  input logic              lk_valid,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [1:0]        lk_fault,
  input logic              wr_en,
  input logic [MASK_W-1:0] wr_mask,
  input logic [VPN_W-1:0]  pr_vpn2,
  input logic [ASID_W-1:0] pr_asid,
  input logic [IDX_W:0]    pr_idx
);

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_pa[11:0] == lk_va[11:0]);

  a_r7_miss_code: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_fault == 2'd1);

  a_r7_invalid_code: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !lk_valid) |-> lk_fault == 2'd2);

  a_r4_legal_mask: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((wr_mask & (wr_mask + 1'b1)) == '0) && ($countones(wr_mask) % 2 == 0)));

  a_r8_probe_agrees: assert property (@(posedge clk) disable iff (rst)
    (pr_vpn2 == lk_va[VA_W-1:13] && pr_asid == lk_asid) |->
      (pr_idx[IDX_W] == !lk_hit) && (!lk_hit || pr_idx[IDX_W-1:0] == lk_idx));

  a_r10_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit && pr_idx[IDX_W]);

endmodule

bind pair_tlb pair_tlb_chk #(
  .IDX_W(IDX_W), .VA_W(VA_W), .PA_W(PFN_W + 12), .ASID_W(ASID_W),
  .MASK_W(MASK_W), .VPN_W(VPN_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid), .lk_pa(lk_pa),
  .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_fault(lk_fault),
  .wr_en(wr_en), .wr_mask(wr_mask), .pr_vpn2(pr_vpn2), .pr_asid(pr_asid),
  .pr_idx(pr_idx)
);

// File: tb/tb_pair_tlb.sv
module tb_pair_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic [31:0] lk_va = 0;
  logic [7:0]  lk_asid = 0;
  logic [1:0]  lk_acc = 0;
  logic [31:0] lk_pa;
  logic        lk_hit, lk_valid, lk_dirty;
  logic [2:0]  lk_cattr;
  logic [4:0]  lk_idx;
  logic [1:0]  lk_fault;
  logic        wr_en = 0;
  logic [4:0]  wr_idx = 0;
  logic [18:0] wr_vpn2 = 0;
  logic [11:0] wr_mask = 0;
  logic [7:0]  wr_asid = 0;
  logic [25:0] wr_lo0 = 0, wr_lo1 = 0;
  logic [18:0] pr_vpn2 = 0;
  logic [7:0]  pr_asid = 0;
  logic [5:0]  pr_idx;

  int n_chk = 0, n_bad = 0;

  pair_tlb dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [25:0] lo(input logic [19:0] pfn, input logic [2:0] c,
                                     input logic d, input logic v, input logic g);
    return {pfn, c, d, v, g};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [4:0] idx, input logic [31:0] va, input logic [11:0] m,
                     input logic [7:0] asid, input logic [25:0] l0, input logic [25:0] l1);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_vpn2 = va[31:13]; wr_mask = m;
    wr_asid = asid; wr_lo0 = l0; wr_lo1 = l1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_acc = acc;
    pr_vpn2 = va[31:13]; pr_asid = asid;
    #1;
  endtask

  task automatic t_reset;
    look(32'h0, 8'h0, 2'd1);
    chk("R10 reset hit", {31'b0, lk_hit}, 0);
    chk("R10 reset probe msb", {31'b0, pr_idx[5]}, 1);
    chk("R7 reset fault", {30'b0, lk_fault}, 1);
  endtask

  task automatic t_basic;
    @(negedge clk);
    wr_en = 1; wr_idx = 5; wr_vpn2 = 19'h12345; wr_mask = 0; wr_asid = 7;
    wr_lo0 = lo(20'hAAAAA, 3, 1, 1, 0); wr_lo1 = lo(20'h55555, 2, 0, 1, 0);
    lk_va = 32'h2468A123; lk_asid = 7; lk_acc = 1;
    #1;
    chk("R10 not before edge", {31'b0, lk_hit}, 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R10 seen after edge", {31'b0, lk_hit}, 1);
    look(32'h2468A123, 7, 2'd1);
    chk("R1 R3 even pa", lk_pa, 32'hAAAAA123);
    chk("R2 idx", {27'b0, lk_idx}, 5);
    chk("R6 even attr", {26'b0, lk_valid, lk_dirty, 1'b0, lk_cattr}, {26'b0, 3'b110, 3'd3});
    chk("R7 load ok", {30'b0, lk_fault}, 0);
    look(32'h2468B456, 7, 2'd1);
    chk("R3 odd pa", lk_pa, 32'h55555456);
    chk("R6 odd attr", {26'b0, lk_valid, lk_dirty, 1'b0, lk_cattr}, {26'b0, 3'b100, 3'd2});
    look(32'h2468B456, 7, 2'd2);
    chk("R7 store protect", {30'b0, lk_fault}, 3);
    look(32'h2468A000, 7, 2'd2);
    chk("R7 store writable", {30'b0, lk_fault}, 0);
    look(32'h2468A123, 8, 2'd0);
    chk("R2 other asid miss", {31'b0, lk_hit}, 0);
    chk("R7 miss code", {30'b0, lk_fault}, 1);
  endtask

  task automatic t_global;
    put(9, 32'h00200000, 0, 3, lo(20'h00009, 3, 1, 1, 1), lo(20'h0000A, 3, 1, 1, 1));
    put(10, 32'h00400000, 0, 3, lo(20'h0000B, 3, 1, 1, 1), lo(20'h0000C, 3, 1, 1, 0));
    look(32'h00200010, 200, 2'd0);
    chk("R5 global any asid", {31'b0, lk_hit}, 1);
    chk("R5 global pa", lk_pa, 32'h00009010);
    look(32'h00400010, 4, 2'd0);
    chk("R5 half global is not global", {31'b0, lk_hit}, 0);
    look(32'h00400010, 3, 2'd0);
    chk("R5 own asid", {31'b0, lk_hit}, 1);
  endtask

  task automatic t_invalid;
    put(11, 32'h00600000, 0, 3, lo(20'h0000D, 2, 1, 0, 0), lo(20'h0000E, 2, 1, 1, 0));
    look(32'h00600000, 3, 2'd0);
    chk("R7 invalid hit", {31'b0, lk_hit}, 1);
    chk("R7 invalid code", {30'b0, lk_fault}, 2);
  endtask

  task automatic t_mask;
    put(12, 32'h10000000, 12'h003, 1, lo(20'h11110, 3, 1, 1, 0), lo(20'h22220, 3, 1, 1, 0));
    look(32'h10002ABC, 1, 2'd1);
    chk("R4 16K even", lk_pa, 32'h11112ABC);
    look(32'h10006ABC, 1, 2'd1);
    chk("R4 16K odd", lk_pa, 32'h22222ABC);
    look(32'h10008000, 1, 2'd1);
    chk("R4 16K outside", {31'b0, lk_hit}, 0);
    put(13, 32'h40000000, 12'hFFF, 1, lo(20'h30000, 3, 1, 1, 0), lo(20'h50000, 3, 1, 1, 0));
    look(32'h40ABCDEF, 1, 2'd1);
    chk("R4 16M even", lk_pa, 32'h30ABCDEF);
    look(32'h41ABCDEF, 1, 2'd1);
    chk("R4 16M odd", lk_pa, 32'h50ABCDEF);
    chk("R4 16M idx", {27'b0, lk_idx}, 13);
  endtask

  task automatic t_prio_probe;
    put(20, 32'h70000000, 0, 1, lo(20'h20000, 3, 1, 1, 0), lo(20'h20001, 3, 1, 1, 0));
    put(2, 32'h70000000, 0, 1, lo(20'h02000, 3, 1, 1, 0), lo(20'h02001, 3, 1, 1, 0));
    look(32'h70000000, 1, 2'd1);
    chk("R9 lowest idx", {27'b0, lk_idx}, 2);
    chk("R9 lowest pa", lk_pa, 32'h02000000);
    chk("R9 probe lowest", {26'b0, pr_idx}, 2);
    look(32'h2468B000, 7, 2'd1);
    chk("R8 probe found", {26'b0, pr_idx}, 5);
    look(32'h2468B000, 9, 2'd1);
    chk("R8 probe miss msb", {31'b0, pr_idx[5]}, 1);
  endtask

  task automatic t_overwrite;
    put(5, 32'h60000000, 0, 7, lo(20'h00777, 3, 1, 1, 0), lo(20'h00778, 3, 1, 1, 0));
    look(32'h2468A123, 7, 2'd1);
    chk("R10 old mapping gone", {31'b0, lk_hit}, 0);
    look(32'h60001000, 7, 2'd1);
    chk("R10 new mapping", lk_pa, 32'h00778000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_global();
    t_invalid();
    t_mask();
    t_prio_probe();
    t_overwrite();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule